// File: doc/BRIEF.md
# MDIO Management Master

This block lets software reach Ethernet PHY management registers over a two-wire MDIO bus. Software programs a frame-type bit, a PHY/register address, a 16-bit outgoing word and a command through a small register interface. It then polls a busy flag and, after a read, collects the 16-bit answer. The block divides its system clock down to MDC and shifts each management frame out on a tri-state MDIO pin: a 32-bit preamble of ones, then the start field, opcode, PHY address, register or device address, turnaround and 16 data bits. On reads it releases the pin for the turnaround and data, and captures what the PHY drives.

Both frame styles are supported. In the short style one command is one complete transaction. In the extended style a transaction takes two commands. An address command carries the 16-bit register address, taken from the outgoing-word register. A following read or write command then reuses the PHY and device numbers already in the address register. The register bus is a plain single-cycle write port with a combinational read mux, driven from the same clock as the sequencer.

The sequencer has three states. SEQ_IDLE holds MDC low and the pin released. On an accepted start it moves to SEQ_MDC_LO, the low half of an MDC period. When the half-period timer expires it moves to SEQ_MDC_HI, the high half, sampling MDIO on the way in. When the high half expires it either returns to SEQ_MDC_LO with the next bit, or, after the last bit, returns to SEQ_IDLE and publishes read data.

Top module: `mdio_mgmt_master`

## Requirements
- R1: After reset every readable register returns 0, MDC is low and the MDIO output enable is low.
- R2: Register offsets are fixed: 0x40 mode (bit 8 = extended frame style, read/write), 0x44 address (bits 12:8 PHY number, bits 4:0 register or device number, read/write), 0x48 outgoing word (bits 15:0, read/write), 0x4C result (bits 15:0, read-only), 0x50 command (write: bit 8 start, bits 1:0 access code; read: bit 16 busy). Unlisted bits read as 0.
- R3: MDC rests low when idle. While busy it runs with half-period HALF = ceil(REF_HZ / (2*MDC_MAX_HZ)) system clocks (20 with defaults, giving 2.5 MHz from 100 MHz), starting with a low half. The driven MDIO bit changes only at MDC falling edges, and is sampled at rising edges.
- R4: A short-style command sends 32 ones, start 01, opcode 01 (code 1, write) or 10 (code 0, read), five PHY bits, five register bits, then for writes turnaround 10 and the outgoing word, MSB first throughout.
- R5: An extended-style command sends 32 ones, start 00, opcode 00 (code 0, address), 01 (code 1, write) or 11 (code 2, read), five PHY bits, five device bits, then for address and write commands turnaround 10 and the outgoing word.
- R6: For read frames the output enable drops for the last 18 bit slots (turnaround and data). The 16 bits sampled in the data slots, MSB first, appear in the result register when the frame ends.
- R7: Busy reads 1 from the clock edge that accepts a start until 128*HALF clocks later, when the frame has fully left the wire.
- R8: A start written while busy is ignored, and the frame in flight continues unchanged. Register writes made during a frame change neither the frame nor the wire.
- R9: In extended style, access code 3 launches nothing and busy stays 0.
- R10: The result register changes only when a read frame completes; write and address frames leave it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock (reference for MDC) |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access select |
| bus_wr | input | 1 | Write strobe, qualified by bus_sel |
| bus_addr | input | 8 | Register byte offset |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data for bus_addr (combinational) |
| mdc | output | 1 | Management clock to the PHYs |
| mdio_in | input | 1 | MDIO pin input from the pad |
| mdio_out | output | 1 | MDIO pin output value |
| mdio_oe | output | 1 | MDIO pin output enable (1 = drive) |

## Verification
The bench goes after the edges of the frame. It checks the first low half of MDC right after the accepting edge: a timer off by one shifts every later bit and the per-clock comparison catches it. It checks the release point at the turnaround, where a design that released late would fight the PHY and one that released early would lose the last driven register bit. It checks the capture window, where sampling one slot early or on the wrong MDC edge scrambles the returned word. A start written mid-frame, a register rewrite under a running frame, and the invalid extended code target sequencers that relaunch or latch late. The result register is watched across write frames to catch a design that overwrites it on every completion.

// File: rtl/mdio_mgmt_pkg.sv
package mdio_mgmt_pkg;

    localparam int PRE_BITS   = 32;
    localparam int FRAME_BITS = PRE_BITS + 32;
    localparam int BIT_W      = $clog2(FRAME_BITS);
    localparam int TA_IDX     = PRE_BITS + 14;
    localparam int DATA_IDX   = PRE_BITS + 16;
    localparam int REG_W      = 32;
    localparam int WORD_W     = 16;
    localparam int ID_W       = 5;

    localparam logic [7:0] OFF_MODE = 8'h40;
    localparam logic [7:0] OFF_ADDR = 8'h44;
    localparam logic [7:0] OFF_WDAT = 8'h48;
    localparam logic [7:0] OFF_RDAT = 8'h4C;
    localparam logic [7:0] OFF_CMD  = 8'h50;

    typedef enum logic [1:0] {
        SEQ_IDLE,
        SEQ_MDC_LO,
        SEQ_MDC_HI
    } seq_state_e;

    typedef struct packed {
        logic [FRAME_BITS-1:0] bits;
        logic                  is_read;
        logic                  valid;
    } frame_t;

endpackage

// File: rtl/mdio_half_timer.sv
module mdio_half_timer #(
    parameter int HALF = 20
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic half_end
);
    localparam int CNT_W = (HALF > 1) ? $clog2(HALF) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(HALF - 1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run || cnt_q == LAST) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign half_end = run && (cnt_q == LAST);

endmodule

// File: rtl/mdio_frame_fmt.sv
module mdio_frame_fmt
    import mdio_mgmt_pkg::*;
(
    input  logic              ext_mode,
    input  logic [1:0]        code,
    input  logic [ID_W-1:0]   phy_id,
    input  logic [ID_W-1:0]   reg_id,
    input  logic [WORD_W-1:0] word,
    output frame_t            frm
);
    logic [1:0]        st_f;
    logic [1:0]        op_f;
    logic [1:0]        ta_f;
    logic [WORD_W-1:0] data_f;
    logic              rd;
    logic              ok;

    always_comb begin
        if (ext_mode) begin
            st_f = 2'b00;
            ok   = (code != 2'd3);
            rd   = (code == 2'd2);
            unique case (code)
                2'd0:    op_f = 2'b00;
                2'd1:    op_f = 2'b01;
                2'd2:    op_f = 2'b11;
                default: op_f = 2'b00;
            endcase
        end else begin
            st_f = 2'b01;
            ok   = 1'b1;
            rd   = ~code[0];
            op_f = code[0] ? 2'b01 : 2'b10;
        end
        ta_f   = rd ? 2'b11 : 2'b10;
        data_f = rd ? {WORD_W{1'b1}} : word;
        frm.bits    = {{PRE_BITS{1'b1}}, st_f, op_f, phy_id, reg_id, ta_f, data_f};
        frm.is_read = rd;
        frm.valid   = ok;
    end

endmodule

// File: rtl/mdio_frame_seq.sv
module mdio_frame_seq
    import mdio_mgmt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              launch,
    input  frame_t            frm,
    input  logic              half_end,
    input  logic              mdio_in,
    output logic              mdc,
    output logic              mdio_out,
    output logic              mdio_oe,
    output logic              busy,
    output logic              rd_done,
    output logic [WORD_W-1:0] cap,
    output logic [BIT_W-1:0]  bit_idx,
    output logic              rd_frame
);
    localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(FRAME_BITS - 1);
    localparam logic [BIT_W-1:0] TA_BIT   = BIT_W'(TA_IDX);
    localparam logic [BIT_W-1:0] DAT_BIT  = BIT_W'(DATA_IDX);

    seq_state_e            state_q, state_d;
    logic [FRAME_BITS-1:0] sh_q;
    logic [BIT_W-1:0]      bit_q;
    logic                  rd_q;
    logic [WORD_W-1:0]     cap_q;
    logic                  last_bit;

    assign last_bit = (bit_q == LAST_BIT);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SEQ_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SEQ_IDLE:   if (launch)   state_d = SEQ_MDC_LO;
            SEQ_MDC_LO: if (half_end) state_d = SEQ_MDC_HI;
            SEQ_MDC_HI: if (half_end) state_d = last_bit ? SEQ_IDLE : SEQ_MDC_LO;
            default:                  state_d = SEQ_IDLE;
        endcase
    end

    // frame shifter, bit counter and capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q  <= '0;
            bit_q <= '0;
            rd_q  <= 1'b0;
            cap_q <= '0;
        end else begin
            unique case (state_q)
                SEQ_IDLE: begin
                    if (launch) begin
                        sh_q  <= frm.bits;
                        bit_q <= '0;
                        rd_q  <= frm.is_read;
                    end
                end
                SEQ_MDC_LO: begin
                    if (half_end && bit_q >= DAT_BIT) begin
                        cap_q <= {cap_q[WORD_W-2:0], mdio_in};
                    end
                end
                SEQ_MDC_HI: begin
                    if (half_end) begin
                        if (last_bit) begin
                            bit_q <= '0;
                        end else begin
                            bit_q <= bit_q + 1'b1;
                            sh_q  <= {sh_q[FRAME_BITS-2:0], 1'b0};
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        busy     = (state_q != SEQ_IDLE);
        mdc      = (state_q == SEQ_MDC_HI);
        mdio_out = sh_q[FRAME_BITS-1];
        mdio_oe  = busy && !(rd_q && bit_q >= TA_BIT);
        rd_done  = (state_q == SEQ_MDC_HI) && half_end && last_bit && rd_q;
        cap      = cap_q;
        bit_idx  = bit_q;
        rd_frame = rd_q;
    end

endmodule

// File: rtl/mdio_mgmt_master.sv
module mdio_mgmt_master
    import mdio_mgmt_pkg::*;
#(
    parameter int REF_HZ     = 100_000_000,
    parameter int MDC_MAX_HZ = 2_500_000
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_sel,
    input  logic        bus_wr,
    input  logic [7:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic        mdc,
    input  logic        mdio_in,
    output logic        mdio_out,
    output logic        mdio_oe
);
    localparam int HALF = (REF_HZ + 2 * MDC_MAX_HZ - 1) / (2 * MDC_MAX_HZ);

    logic              ext_q;
    logic [ID_W-1:0]   phy_q;
    logic [ID_W-1:0]   reg_q;
    logic [WORD_W-1:0] wdat_q;
    logic [WORD_W-1:0] rdat_q;

    logic              wr_en;
    logic              cmd_start_wr;
    logic              launch;
    logic              busy;
    logic              half_end;
    logic              rd_done;
    logic              rd_frame;
    logic [WORD_W-1:0] cap;
    logic [BIT_W-1:0]  bit_idx;
    frame_t            frm;
    logic              unused_bits;

    assign wr_en        = bus_sel && bus_wr;
    assign cmd_start_wr = wr_en && (bus_addr == OFF_CMD) && bus_wdata[8];
    assign launch       = cmd_start_wr && !busy && frm.valid;
    assign unused_bits  = ^{bus_wdata[31:17], bus_wdata[16], bus_wdata[7:5], bus_wdata[15:13]};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ext_q  <= 1'b0;
            phy_q  <= '0;
            reg_q  <= '0;
            wdat_q <= '0;
        end else if (wr_en) begin
            unique case (bus_addr)
                OFF_MODE: ext_q  <= bus_wdata[8];
                OFF_ADDR: begin
                    phy_q <= bus_wdata[12:8];
                    reg_q <= bus_wdata[4:0];
                end
                OFF_WDAT: wdat_q <= bus_wdata[15:0];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdat_q <= '0;
        end else if (rd_done) begin
            rdat_q <= cap;
        end
    end

    always_comb begin
        bus_rdata = '0;
        unique case (bus_addr)
            OFF_MODE: bus_rdata[8]     = ext_q;
            OFF_ADDR: begin
                bus_rdata[12:8] = phy_q;
                bus_rdata[4:0]  = reg_q;
            end
            OFF_WDAT: bus_rdata[15:0]  = wdat_q;
            OFF_RDAT: bus_rdata[15:0]  = rdat_q;
            OFF_CMD:  bus_rdata[16]    = busy;
            default: ;
        endcase
    end

    mdio_frame_fmt u_fmt (
        .ext_mode (ext_q),
        .code     (bus_wdata[1:0]),
        .phy_id   (phy_q),
        .reg_id   (reg_q),
        .word     (wdat_q),
        .frm      (frm)
    );

    mdio_half_timer #(.HALF(HALF)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (busy),
        .half_end (half_end)
    );

    mdio_frame_seq u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .launch   (launch),
        .frm      (frm),
        .half_end (half_end),
        .mdio_in  (mdio_in),
        .mdc      (mdc),
        .mdio_out (mdio_out),
        .mdio_oe  (mdio_oe),
        .busy     (busy),
        .rd_done  (rd_done),
        .cap      (cap),
        .bit_idx  (bit_idx),
        .rd_frame (rd_frame)
    );

endmodule

// File: rtl/mdio_mgmt_checker.sv
module mdio_mgmt_checker
    import mdio_mgmt_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             mdc,
    input logic             mdio_out,
    input logic             mdio_oe,
    input logic             busy,
    input logic             launch,
    input logic             cmd_start_wr,
    input logic [BIT_W-1:0] bit_idx,
    input logic             rd_frame
);
    // R3: MDC rests low outside a frame
    p_mdc_rest_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mdc);

    // R3: driven data holds through the high half of MDC
    p_out_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mdc && $past(mdc)) |-> $stable(mdio_out));

    // R7: an accepted start raises busy at the next edge
    p_busy_rise_r7: assert property (@(posedge clk) disable iff (!rst_n)
        launch |=> busy);

    // R8: a start during a frame does not restart it
    p_no_restart_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cmd_start_wr && bit_idx != '0) |=> (bit_idx != '0 || !busy));

    // R6: pin released for turnaround and data of reads
    p_read_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && rd_frame && bit_idx >= BIT_W'(TA_IDX)) |-> !mdio_oe);

    // R4: write and address frames drive every slot
    p_write_drive_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !rd_frame) |-> mdio_oe);

endmodule

bind mdio_mgmt_master mdio_mgmt_checker u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .mdc          (mdc),
    .mdio_out     (mdio_out),
    .mdio_oe      (mdio_oe),
    .busy         (busy),
    .launch       (launch),
    .cmd_start_wr (cmd_start_wr),
    .bit_idx      (bit_idx),
    .rd_frame     (rd_frame)
);

// File: tb/mdio_mgmt_master_bench.sv
`timescale 1ns/1ps
module mdio_mgmt_master_bench;
    localparam int REF_HZ  = 100_000_000;
    localparam int MAX_HZ  = 2_500_000;
    localparam int HALF    = REF_HZ / (2 * MAX_HZ);
    localparam int FRAME_T = 128 * HALF;
    localparam bit [7:0] A_MODE = 8'h40, A_ADDR = 8'h44, A_WDAT = 8'h48,
                         A_RDAT = 8'h4C, A_CMD = 8'h50;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        bus_sel, bus_wr;
    logic [7:0]  bus_addr;
    logic [31:0] bus_wdata, bus_rdata;
    logic        mdc, mdio_in, mdio_out, mdio_oe;

    always #2 clk = ~clk;

    mdio_mgmt_master u_mdio_mgmt_master (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .mdc(mdc), .mdio_in(mdio_in), .mdio_out(mdio_out), .mdio_oe(mdio_oe)
    );

    // behavioural reference state
    int        mt = -1;
    bit        m_ext;
    bit [4:0]  m_phy, m_low;
    bit [15:0] m_wdat, m_rdat, m_phyval;
    bit        m_read;
    bit        exp_bits[$];
    int        compared = 0, mismatched = 0, cycles = 0;
    string     ctx = "R1";
    bit        ended = 0;

    function automatic void chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s %s %s: actual=%0h expected=%0h", ctx, tag, what, act, exp);
        end
    endfunction

    function automatic void push_field(int v, int n);
        for (int i = n - 1; i >= 0; i--) exp_bits.push_back(bit'((v >> i) & 1));
    endfunction

    function automatic void build(bit [1:0] code);
        exp_bits.delete();
        push_field(-1, 32);
        if (m_ext) begin
            push_field(0, 2);
            push_field((code == 0) ? 0 : (code == 1) ? 1 : 3, 2);
            m_read = (code == 2);
        end else begin
            push_field(1, 2);
            push_field(code[0] ? 1 : 2, 2);
            m_read = !code[0];
        end
        push_field(m_phy, 5);
        push_field(m_low, 5);
        push_field(2, 2);
        push_field(m_wdat, 16);
    endfunction

    function automatic void compare_all();
        int b;
        bit [31:0] er;
        b = (mt >= 0) ? mt / (2 * HALF) : 0;
        chk("R3", "mdc", mdc, (mt >= 0) ? ((mt / HALF) % 2) : 0);
        chk("R6", "mdio_oe", mdio_oe, (mt >= 0) && !(m_read && b >= 46));
        if ((mt >= 0) && !(m_read && b >= 46))
            chk(m_ext ? "R5" : "R4", "mdio_out", mdio_out, exp_bits[b]);
        er = 0;
        case (bus_addr)
            A_MODE: er = {23'd0, m_ext, 8'd0};
            A_ADDR: er = {19'd0, m_phy, 3'd0, m_low};
            A_WDAT: er = {16'd0, m_wdat};
            A_RDAT: er = {16'd0, m_rdat};
            A_CMD:  er = (mt >= 0) ? 32'h1_0000 : 32'h0;
            default: er = 0;
        endcase
        chk((bus_addr == A_CMD) ? "R7" : (bus_addr == A_RDAT) ? "R10" : "R2",
            "bus_rdata", bus_rdata, er);
    endfunction

    task automatic finish_run();
        if (!ended) begin
            ended = 1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    endtask

    task automatic cycle(bit sel, bit wr, bit [7:0] a, bit [31:0] d);
        int b;
        bus_sel = sel; bus_wr = wr; bus_addr = a; bus_wdata = d;
        b = (mt >= 0) ? mt / (2 * HALF) : 0;
        mdio_in = (mt >= 0 && m_read && b >= 48) ? m_phyval[63 - b] : 1'b1;
        // reference update for the coming edge
        if (mt >= 0) begin
            mt++;
            if (mt == FRAME_T) begin
                mt = -1;
                if (m_read) m_rdat = m_phyval;
            end
        end else if (sel && wr && a == A_CMD && d[8] && !(m_ext && d[1:0] == 2'd3)) begin
            build(d[1:0]);
            mt = 0;
        end
        if (sel && wr) begin
            if (a == A_MODE) m_ext = d[8];
            if (a == A_ADDR) begin m_phy = d[12:8]; m_low = d[4:0]; end
            if (a == A_WDAT) m_wdat = d[15:0];
        end
        @(negedge clk);
        cycles++;
        compare_all();
        if (cycles > 190_000) begin
            mismatched++;
            compared++;
            $display("FAIL %s watchdog: actual=%0d expected=%0d", ctx, cycles, 190_000);
            finish_run();
        end
    endtask

    task automatic wr(bit [7:0] a, bit [31:0] d);
        cycle(1'b1, 1'b1, a, d);
    endtask

    task automatic idle(int n, bit [7:0] a);
        for (int i = 0; i < n; i++) cycle(1'b0, 1'b0, a, 32'd0);
    endtask

    task automatic drain(bit [7:0] a);
        while (mt >= 0) cycle(1'b0, 1'b0, a, 32'd0);
        idle(3, a);
    endtask

    initial begin
        rst_n = 1'b0; bus_sel = 0; bus_wr = 0; bus_addr = 8'h0; bus_wdata = 0; mdio_in = 1'b1;
        repeat (3) @(negedge clk);
        // R1: reset values seen through every offset
        ctx = "R1";
        compare_all();
        rst_n = 1'b1;
        idle(1, A_MODE); idle(1, A_ADDR); idle(1, A_WDAT); idle(1, A_RDAT); idle(1, A_CMD);

        // R2: register field placement and masking
        ctx = "R2";
        wr(A_MODE, 32'hFFFF_FFFF); idle(1, A_MODE);
        wr(A_ADDR, 32'hFFFF_FFFF); idle(1, A_ADDR);
        wr(A_WDAT, 32'hFFFF_A5A5); idle(1, A_WDAT);
        wr(A_MODE, 32'h0);         idle(1, A_MODE);

        // R4: short-style write frame
        ctx = "R4";
        wr(A_ADDR, (5 << 8) | 3);
        wr(A_WDAT, 32'h1234);
        wr(A_CMD, 32'h101);
        drain(A_CMD);

        // R6: short-style read, release and capture
        ctx = "R6";
        m_phyval = 16'hBEEF;
        wr(A_ADDR, (17 << 8) | 2);
        wr(A_CMD, 32'h100);
        drain(A_RDAT);

        // R10: a write frame leaves the result alone
        ctx = "R10";
        wr(A_WDAT, 32'h0F0F);
        wr(A_CMD, 32'h101);
        drain(A_RDAT);

        // R5: extended address then write
        ctx = "R5";
        wr(A_MODE, 32'h100);
        wr(A_ADDR, (2 << 8) | 7);
        wr(A_WDAT, 32'h8001);
        wr(A_CMD, 32'h100);
        drain(A_RDAT);
        wr(A_WDAT, 32'h5555);
        wr(A_CMD, 32'h101);
        drain(A_CMD);

        // R8: extended read with a start and register writes mid-frame
        ctx = "R8";
        m_phyval = 16'h0F1E;
        wr(A_CMD, 32'h102);
        idle(100, A_CMD);
        wr(A_CMD, 32'h101);
        wr(A_WDAT, 32'hAAAA);
        wr(A_ADDR, (9 << 8) | 1);
        idle(700, A_CMD);
        wr(A_CMD, 32'h100);
        drain(A_RDAT);

        // R9: invalid extended code launches nothing
        ctx = "R9";
        wr(A_CMD, 32'h103);
        idle(10, A_CMD);

        // R3: MDC timing on a further short-style read
        ctx = "R3";
        wr(A_MODE, 32'h0);
        m_phyval = 16'h8001;
        wr(A_CMD, 32'h100);
        drain(A_RDAT);

        finish_run();
    end

endmodule